// File: doc/BRIEF.md
# Address Translation Fault Sequencer

This block handles one address translation request at a time. A request is an instruction fetch, a load or a store. The block walks a fixed chain of checks and ends each request with exactly one outcome: either a translated real address with its access rights, or an exception with a status code.

The checks run in this order:
- **Relocation.** When relocation is off for the access side, the address passes through untouched with full rights.
- **Block matcher.** An external block matcher is asked next; a hit ends the request.
- **Segment register.** On a miss, the block picks a segment register by the top effective-address bits.
  - A direct-store segment is resolved locally.
  - A fetch from a no-execute segment faults.
- **Page-table searcher.** Otherwise an external page-table searcher is asked for a page entry.
- **Rights check.** The rights of the entry are derived from its two protection bits and the access key.

The matcher and the searcher sit outside the block. They are asked through level requests, held high until they answer with a valid strobe. Data faults and alignment faults copy the effective address into a fault-address register. Instruction faults and successful requests leave that register alone.

Top module: `xlat_fault_seq`

## Requirements
- R1: `req_ready` is high only while idle, and is 1 after reset with `done_valid` 0 and `fault_addr` 0. Each accepted request gives exactly one single-cycle `done_valid` pulse. `req_ready` stays low from acceptance until that pulse, and the pulse waits for any slow matcher or searcher response.
- R2: With `xlate_fetch_en`=0 for a fetch (kind 2), or `xlate_data_en`=0 for a load (kind 0) or store (kind 1), the outcome is `done_raddr` equal to the effective address and `done_perm`=3'b111 (bit2 execute, bit1 write, bit0 read). Neither `blk_req` nor `pt_req` is raised.
- R3: The block matcher is asked before any segment lookup. A hit whose `blk_perm` holds the needed right (load: bit0, store: bit1, fetch: bit2) completes with `blk_raddr` and `blk_perm`, and no page-table search.
- R4: A rights violation faults as follows. A fetch gives `done_exc`=1 (instruction fault) with code 0x08000000. A data access gives `done_exc`=2 (data fault) with 0x0A000000 for a store or 0x08000000 for a load. This applies to both block hits and page entries.
- R5: The segment register is entry `ea[31:28]` of `seg_regs`; entry i is `seg_regs[32*i+31:32*i]`. Its fields are:
  - bit31: direct-store flag
  - bit30: supervisor key
  - bit29: user key
  - bit28: no-execute
  - bits 28:20: bus-unit ID
  - bits 23:0: VSID, sent on `pt_vsid`
- R6: The access key is the user-key bit when `req_user`=1, else the supervisor-key bit.
- R7: Page rights from `pt_pp` and the key are:
  - With key 0: pp 0 to 2 give read+write, and pp 3 gives read only.
  - With key 1: pp 0 gives nothing, pp 2 gives read+write, and pp 1 or 3 give read only.
  - Execute is granted when read is granted and the segment is not no-execute.
- R8: In a direct-store segment with bus-unit ID 0x07F, the result is `{sr[3:0], ea[27:0]}` with `done_perm`=3'b111 for any access, unchecked.
- R9: In any other direct-store segment, the checks run in this order:
  - A fetch gives an instruction fault with code 0x10000000.
  - A floating-point access (`req_fp`=1) gives `done_exc`=3 (alignment) with code 0.
  - A load with key 1, or a store with key 0, gives a data fault (0x08000000 load, 0x0A000000 store).
  - Otherwise the result is the effective address with `done_perm`=3'b011.
- R10: A fetch from a non-direct-store segment with the no-execute bit set gives an instruction fault with code 0x10000000, without a page-table search.
- R11: A page-table miss gives an instruction fault with code 0x40000000 for a fetch. A data miss gives 0x42000000 for a store or 0x40000000 for a load.
- R12: A page hit with the needed right gives `{pt_rpn, ea[11:0]}` and the R7 rights. Every fault outcome has `done_perm`=0 and `done_raddr`=0.
- R13: Every data fault and alignment fault loads `fault_addr` with the effective address. Instruction faults and successful outcomes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ea | input | 32 | Effective address |
| req_fp | input | 1 | Floating-point data access |
| req_user | input | 1 | Problem (user) state |
| xlate_fetch_en | input | 1 | Instruction relocation enabled |
| xlate_data_en | input | 1 | Data relocation enabled |
| seg_regs | input | 512 | Sixteen 32-bit segment registers |
| blk_req | output | 1 | Block matcher request, held until response |
| blk_ea | output | 32 | Address for the block matcher |
| blk_kind | output | 2 | Access kind for the block matcher |
| blk_user | output | 1 | Privilege for the block matcher |
| blk_rsp_valid | input | 1 | Block matcher answer valid |
| blk_hit | input | 1 | Block matched |
| blk_raddr | input | 32 | Real address from the block |
| blk_perm | input | 3 | Block rights {x,w,r} |
| pt_req | output | 1 | Page-table search request, held until response |
| pt_vsid | output | 24 | Virtual segment ID |
| pt_ea | output | 32 | Address for the search |
| pt_rsp_valid | input | 1 | Search answer valid |
| pt_found | input | 1 | Page entry found |
| pt_rpn | input | 20 | Real page number |
| pt_pp | input | 2 | Page protection bits |
| done_valid | output | 1 | Outcome pulse |
| done_exc | output | 2 | 0 none, 1 instruction fault, 2 data fault, 3 alignment |
| done_code | output | 32 | Fault status code |
| done_raddr | output | 32 | Translated real address |
| done_perm | output | 3 | Granted rights {x,w,r} |
| fault_addr | output | 32 | Last data/alignment fault address |

## Verification
The assertions check these properties on every cycle:
- The outcome is a single-cycle pulse.
- The two external requests never overlap.
- The real-mode bypass completes in the cycle after evaluation.
- Faults carry no rights.
- Data faults load the fault address.
- Instruction faults leave the fault address unchanged.

Only the bench scenarios can show the rest:
- the exact status codes per cause and direction;
- the order of the checks;
- the rights table;
- segment selection at the address extremes;
- the wait on a stalled page-table searcher.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int SR_W       = 32;
    localparam int STAT_W     = 32;
    localparam int SR_T_BIT   = 31;
    localparam int SR_KS_BIT  = 30;
    localparam int SR_KP_BIT  = 29;
    localparam int SR_NX_BIT  = 28;
    localparam int SR_BUS_HI  = 28;
    localparam int SR_BUS_LO  = 20;
    localparam int BUS_W      = SR_BUS_HI - SR_BUS_LO + 1;
    localparam logic [BUS_W-1:0] BUS_ID_FORCED = 9'h07F;

    localparam logic [STAT_W-1:0] ST_NOEXEC     = 32'h1000_0000;
    localparam logic [STAT_W-1:0] ST_NOPTE      = 32'h4000_0000;
    localparam logic [STAT_W-1:0] ST_PROT       = 32'h0800_0000;
    localparam logic [STAT_W-1:0] ST_STORE_FLAG = 32'h0200_0000;

    localparam logic [2:0] PERM_R = 3'b001;
    localparam logic [2:0] PERM_W = 3'b010;
    localparam logic [2:0] PERM_X = 3'b100;

    typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_ISI = 2'd1, EXC_DSI = 2'd2, EXC_ALIGN = 2'd3} exc_e;
    typedef enum logic [2:0] {S_IDLE = 3'd0, S_EVAL = 3'd1, S_BLK = 3'd2, S_SEG = 3'd3, S_PT = 3'd4} st_e;

    function automatic logic [2:0] need_mask(acc_e k);
        case (k)
            ACC_STORE: need_mask = PERM_W;
            ACC_FETCH: need_mask = PERM_X;
            default:   need_mask = PERM_R;
        endcase
    endfunction
endpackage

// File: rtl/xlat_seg_sel.sv
module xlat_seg_sel
    import xlat_pkg::*;
#(
    parameter int SEG_IDX_W = 4,
    parameter int VSID_W    = 24
) (
    input  logic [(1<<SEG_IDX_W)*SR_W-1:0] seg_regs,
    input  logic [SEG_IDX_W-1:0]           idx,
    input  logic                           user,
    output logic                           sr_t,
    output logic                           sr_nx,
    output logic                           key,
    output logic [BUS_W-1:0]               bus_id,
    output logic [SEG_IDX_W-1:0]           sr_low,
    output logic [VSID_W-1:0]              vsid
);
    localparam int NUM_SEG = 1 << SEG_IDX_W;

    logic [SR_W-1:0] entry [NUM_SEG];
    logic [SR_W-1:0] sel;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
        assign entry[g] = seg_regs[g*SR_W +: SR_W];
    end

    assign sel    = entry[idx];
    assign sr_t   = sel[SR_T_BIT];
    assign sr_nx  = sel[SR_NX_BIT];
    assign key    = user ? sel[SR_KP_BIT] : sel[SR_KS_BIT];
    assign bus_id = sel[SR_BUS_HI:SR_BUS_LO];
    assign sr_low = sel[SEG_IDX_W-1:0];
    assign vsid   = sel[VSID_W-1:0];
endmodule

// File: rtl/xlat_pp_perm.sv
module xlat_pp_perm
    import xlat_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       nx,
    output logic [2:0] perm
);
    logic [2:0] rw;

    always_comb begin
        if (!key) begin
            rw = (pp == 2'd3) ? PERM_R : (PERM_R | PERM_W);
        end else begin
            case (pp)
                2'd0:    rw = 3'b000;
                2'd2:    rw = PERM_R | PERM_W;
                default: rw = PERM_R;
            endcase
        end
        perm = rw | ((rw[0] && !nx) ? PERM_X : 3'b000);
    end
endmodule

// File: rtl/xlat_ds_eval.sv
module xlat_ds_eval
    import xlat_pkg::*;
#(
    parameter int EA_W      = 32,
    parameter int SEG_IDX_W = 4
) (
    input  logic [BUS_W-1:0]     bus_id,
    input  logic [SEG_IDX_W-1:0] sr_low,
    input  logic [EA_W-1:0]      ea,
    input  acc_e                 kind,
    input  logic                 fp,
    input  logic                 key,
    output exc_e                 exc,
    output logic [STAT_W-1:0]    code,
    output logic [EA_W-1:0]      raddr,
    output logic [2:0]           perm
);
    localparam int OFF_W = EA_W - SEG_IDX_W;

    always_comb begin
        exc   = EXC_NONE;
        code  = '0;
        raddr = '0;
        perm  = '0;
        if (bus_id == BUS_ID_FORCED) begin
            raddr = {sr_low, ea[OFF_W-1:0]};
            perm  = PERM_R | PERM_W | PERM_X;
        end else if (kind == ACC_FETCH) begin
            exc  = EXC_ISI;
            code = ST_NOEXEC;
        end else if (fp) begin
            exc  = EXC_ALIGN;
        end else if ((kind == ACC_LOAD && key) || (kind == ACC_STORE && !key)) begin
            exc  = EXC_DSI;
            code = ST_PROT | ((kind == ACC_STORE) ? ST_STORE_FLAG : '0);
        end else begin
            raddr = ea;
            perm  = PERM_R | PERM_W;
        end
    end
endmodule

// File: rtl/xlat_fault_seq.sv
module xlat_fault_seq
    import xlat_pkg::*;
#(
    parameter int EA_W      = 32,
    parameter int SEG_IDX_W = 4,
    parameter int PAGE_W    = 12,
    parameter int VSID_W    = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [1:0]                       req_kind,
    input  logic [EA_W-1:0]                  req_ea,
    input  logic                             req_fp,
    input  logic                             req_user,
    input  logic                             xlate_fetch_en,
    input  logic                             xlate_data_en,
    input  logic [(1<<SEG_IDX_W)*32-1:0]     seg_regs,
    output logic                             blk_req,
    output logic [EA_W-1:0]                  blk_ea,
    output logic [1:0]                       blk_kind,
    output logic                             blk_user,
    input  logic                             blk_rsp_valid,
    input  logic                             blk_hit,
    input  logic [EA_W-1:0]                  blk_raddr,
    input  logic [2:0]                       blk_perm,
    output logic                             pt_req,
    output logic [VSID_W-1:0]                pt_vsid,
    output logic [EA_W-1:0]                  pt_ea,
    input  logic                             pt_rsp_valid,
    input  logic                             pt_found,
    input  logic [EA_W-PAGE_W-1:0]           pt_rpn,
    input  logic [1:0]                       pt_pp,
    output logic                             done_valid,
    output logic [1:0]                       done_exc,
    output logic [31:0]                      done_code,
    output logic [EA_W-1:0]                  done_raddr,
    output logic [2:0]                       done_perm,
    output logic [EA_W-1:0]                  fault_addr
);
    localparam int RPN_W = EA_W - PAGE_W;

    typedef struct packed {
        st_e               state;
        logic [EA_W-1:0]   ea;
        acc_e              kind;
        logic              fp;
        logic              user;
        logic              reloc;
        logic [VSID_W-1:0] vsid;
        logic              nx;
        logic              key;
        logic              done_valid;
        exc_e              exc;
        logic [STAT_W-1:0] code;
        logic [EA_W-1:0]   raddr;
        logic [2:0]        perm;
        logic [EA_W-1:0]   fault_addr;
    } ctx_t;

    ctx_t q, d;

    logic                 seg_t, seg_nx, seg_key;
    logic [BUS_W-1:0]     seg_bus;
    logic [SEG_IDX_W-1:0] seg_low;
    logic [VSID_W-1:0]    seg_vsid;
    exc_e                 ds_exc;
    logic [STAT_W-1:0]    ds_code;
    logic [EA_W-1:0]      ds_raddr;
    logic [2:0]           ds_perm;
    logic [2:0]           pg_perm;

    xlat_seg_sel #(.SEG_IDX_W(SEG_IDX_W), .VSID_W(VSID_W)) u_seg (
        .seg_regs (seg_regs),
        .idx      (q.ea[EA_W-1 -: SEG_IDX_W]),
        .user     (q.user),
        .sr_t     (seg_t),
        .sr_nx    (seg_nx),
        .key      (seg_key),
        .bus_id   (seg_bus),
        .sr_low   (seg_low),
        .vsid     (seg_vsid)
    );

    xlat_ds_eval #(.EA_W(EA_W), .SEG_IDX_W(SEG_IDX_W)) u_ds (
        .bus_id (seg_bus),
        .sr_low (seg_low),
        .ea     (q.ea),
        .kind   (q.kind),
        .fp     (q.fp),
        .key    (seg_key),
        .exc    (ds_exc),
        .code   (ds_code),
        .raddr  (ds_raddr),
        .perm   (ds_perm)
    );

    xlat_pp_perm u_pp (
        .key  (q.key),
        .pp   (pt_pp),
        .nx   (q.nx),
        .perm (pg_perm)
    );

    logic              fin;
    exc_e              fin_exc;
    logic [STAT_W-1:0] fin_code;
    logic [EA_W-1:0]   fin_raddr;
    logic [2:0]        fin_perm;
    logic [2:0]        need;
    logic [STAT_W-1:0] st_flag;
    logic              is_fetch;
    exc_e              side_exc;

    always_comb begin
        d           = q;
        d.done_valid = 1'b0;
        fin         = 1'b0;
        fin_exc     = EXC_NONE;
        fin_code    = '0;
        fin_raddr   = '0;
        fin_perm    = '0;
        need        = need_mask(q.kind);
        is_fetch    = (q.kind == ACC_FETCH);
        st_flag     = (q.kind == ACC_STORE) ? ST_STORE_FLAG : '0;
        side_exc    = is_fetch ? EXC_ISI : EXC_DSI;

        case (q.state)
            S_IDLE: begin
                if (req_valid) begin
                    d.state = S_EVAL;
                    d.ea    = req_ea;
                    d.kind  = acc_e'(req_kind);
                    d.fp    = req_fp;
                    d.user  = req_user;
                    d.reloc = (req_kind == ACC_FETCH) ? xlate_fetch_en : xlate_data_en;
                end
            end
            S_EVAL: begin
                if (!q.reloc) begin
                    fin       = 1'b1;
                    fin_raddr = q.ea;
                    fin_perm  = PERM_R | PERM_W | PERM_X;
                end else begin
                    d.state = S_BLK;
                end
            end
            S_BLK: begin
                if (blk_rsp_valid) begin
                    if (blk_hit) begin
                        fin = 1'b1;
                        if ((blk_perm & need) == 3'b000) begin
                            fin_exc  = side_exc;
                            fin_code = ST_PROT | st_flag;
                        end else begin
                            fin_raddr = blk_raddr;
                            fin_perm  = blk_perm;
                        end
                    end else begin
                        d.state = S_SEG;
                    end
                end
            end
            S_SEG: begin
                d.vsid = seg_vsid;
                d.nx   = seg_nx;
                d.key  = seg_key;
                if (seg_t) begin
                    fin       = 1'b1;
                    fin_exc   = ds_exc;
                    fin_code  = ds_code;
                    fin_raddr = ds_raddr;
                    fin_perm  = ds_perm;
                end else if (is_fetch && seg_nx) begin
                    fin      = 1'b1;
                    fin_exc  = EXC_ISI;
                    fin_code = ST_NOEXEC;
                end else begin
                    d.state = S_PT;
                end
            end
            S_PT: begin
                if (pt_rsp_valid) begin
                    fin = 1'b1;
                    if (!pt_found) begin
                        fin_exc  = side_exc;
                        fin_code = ST_NOPTE | st_flag;
                    end else if ((pg_perm & need) == 3'b000) begin
                        fin_exc  = side_exc;
                        fin_code = ST_PROT | st_flag;
                    end else begin
                        fin_raddr = {pt_rpn, q.ea[PAGE_W-1:0]};
                        fin_perm  = pg_perm;
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (fin) begin
            d.state      = S_IDLE;
            d.done_valid = 1'b1;
            d.exc        = fin_exc;
            d.code       = fin_code;
            d.raddr      = fin_raddr;
            d.perm       = fin_perm;
            if (fin_exc == EXC_DSI || fin_exc == EXC_ALIGN) begin
                d.fault_addr = q.ea;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.state == S_IDLE);
    assign blk_req    = (q.state == S_BLK);
    assign blk_ea     = q.ea;
    assign blk_kind   = q.kind;
    assign blk_user   = q.user;
    assign pt_req     = (q.state == S_PT);
    assign pt_vsid    = q.vsid;
    assign pt_ea      = q.ea;
    assign done_valid = q.done_valid;
    assign done_exc   = q.exc;
    assign done_code  = q.code;
    assign done_raddr = q.raddr;
    assign done_perm  = q.perm;
    assign fault_addr = q.fault_addr;

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R1
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_req && pt_req) && !(req_ready && (blk_req || pt_req)));

    // R2
    real_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_EVAL && !q.reloc) |=>
            (done_valid && done_exc == EXC_NONE && done_perm == 3'b111
             && done_raddr == $past(q.ea)));

    // R12
    fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_exc != EXC_NONE) |-> (done_perm == 3'b000 && done_raddr == '0));

    // R13
    data_fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_exc == EXC_DSI || done_exc == EXC_ALIGN)) |-> fault_addr == q.ea);

    // R13
    inst_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_exc == EXC_ISI || done_exc == EXC_NONE)) |-> $stable(fault_addr));

    // R10
    nx_no_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |-> !(q.kind == ACC_FETCH && q.nx));
endmodule

// File: tb/xlat_fault_seq_tb.sv
`timescale 1ns/1ps
module xlat_fault_seq_tb;
    localparam logic [31:0] EA     = 32'h3456_7ABC;
    localparam logic [31:0] BLK_RA = 32'h8000_0ABC;
    localparam logic [19:0] RPN    = 20'hABCDE;
    localparam logic [31:0] PT_RA  = 32'hABCD_EABC;
    localparam logic [31:0] DS7_RA = 32'h5456_7ABC;
    localparam logic [31:0] POISON = 32'hF000_0000;

    typedef struct packed {
        logic [1:0]  kind;
        logic        fp, user, ir, dr, bhit;
        logic [2:0]  bperm;
        logic [31:0] sr;
        logic        pfound;
        logic [1:0]  pp;
        logic [1:0]  xexc;
        logic [31:0] xcode;
        logic [31:0] xraddr;
        logic [2:0]  xperm;
        logic        xblk, xpt;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,32'h0,1'b0,2'd0, 2'd0,32'h0,        EA,    3'b111,1'b0,1'b0},
        '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,32'h0,1'b0,2'd0, 2'd0,32'h0,        EA,    3'b111,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b1,3'b011,32'h0,1'b0,2'd0, 2'd0,32'h0,        BLK_RA,3'b011,1'b1,1'b0},
        '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b1,3'b101,32'h0,1'b0,2'd0, 2'd2,32'h0A00_0000,32'h0, 3'b000,1'b1,1'b0},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b1,3'b011,32'h0,1'b0,2'd0, 2'd1,32'h0800_0000,32'h0, 3'b000,1'b1,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b1,3'b100,32'h0,1'b0,2'd0, 2'd2,32'h0800_0000,32'h0, 3'b000,1'b1,1'b0},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h87F0_0005,1'b0,2'd0, 2'd0,32'h0,DS7_RA,3'b111,1'b1,1'b0},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h8000_0000,1'b0,2'd0, 2'd1,32'h1000_0000,32'h0,3'b000,1'b1,1'b0},
        '{2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,3'b000,32'h8000_0000,1'b0,2'd0, 2'd3,32'h0,32'h0,3'b000,1'b1,1'b0},
        '{2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'hA000_0000,1'b0,2'd0, 2'd2,32'h0800_0000,32'h0,3'b000,1'b1,1'b0},
        '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h8000_0000,1'b0,2'd0, 2'd2,32'h0A00_0000,32'h0,3'b000,1'b1,1'b0},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'hA000_0000,1'b0,2'd0, 2'd0,32'h0,EA,3'b011,1'b1,1'b0},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h1000_0000,1'b0,2'd0, 2'd1,32'h1000_0000,32'h0,3'b000,1'b1,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h0000_0123,1'b0,2'd0, 2'd2,32'h4000_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h0000_0123,1'b0,2'd0, 2'd2,32'h4200_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h0000_0123,1'b0,2'd0, 2'd1,32'h4000_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h0000_0123,1'b1,2'd0, 2'd0,32'h0,PT_RA,3'b111,1'b1,1'b1},
        '{2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'h2000_0123,1'b1,2'd0, 2'd2,32'h0800_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'h2000_0123,1'b1,2'd1, 2'd2,32'h0A00_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'h2000_0123,1'b1,2'd2, 2'd0,32'h0,PT_RA,3'b111,1'b1,1'b1},
        '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h0000_0123,1'b1,2'd3, 2'd2,32'h0A00_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd1,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'h4000_0123,1'b1,2'd0, 2'd0,32'h0,PT_RA,3'b111,1'b1,1'b1},
        '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h4000_0123,1'b1,2'd0, 2'd1,32'h0800_0000,32'h0,3'b000,1'b1,1'b1},
        '{2'd2,1'b0,1'b1,1'b1,1'b1,1'b0,3'b000,32'h2000_0123,1'b1,2'd3, 2'd0,32'h0,PT_RA,3'b101,1'b1,1'b1},
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,3'b000,32'h1000_0123,1'b1,2'd2, 2'd0,32'h0,PT_RA,3'b011,1'b1,1'b1}
    };
    localparam string TAGS [NV] = '{
        "R2","R2","R3","R4","R4","R4","R8","R9","R9","R9","R9","R9","R10",
        "R11","R11","R11","R12","R7","R7","R7","R7","R6","R6","R7","R12"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_ea = '0;
    logic        req_fp = 1'b0, req_user = 1'b0;
    logic        xlate_fetch_en = 1'b1, xlate_data_en = 1'b1;
    logic [511:0] seg_regs = '0;
    logic        blk_req, blk_user;
    logic [31:0] blk_ea;
    logic [1:0]  blk_kind;
    logic        blk_hit = 1'b0;
    logic [2:0]  blk_perm = '0;
    logic        pt_req;
    logic [23:0] pt_vsid;
    logic [31:0] pt_ea;
    logic        pt_gate = 1'b1;
    logic        pt_found = 1'b0;
    logic [1:0]  pt_pp = '0;
    logic        done_valid;
    logic [1:0]  done_exc;
    logic [31:0] done_code, done_raddr, fault_addr;
    logic [2:0]  done_perm;

    int total = 0, bad = 0;
    logic [31:0] exp_fa = '0;
    logic got_blk, got_pt, busy_bad;
    int lat;

    always #5 clk = ~clk;

    xlat_fault_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_ea(req_ea), .req_fp(req_fp), .req_user(req_user),
        .xlate_fetch_en(xlate_fetch_en), .xlate_data_en(xlate_data_en), .seg_regs(seg_regs),
        .blk_req(blk_req), .blk_ea(blk_ea), .blk_kind(blk_kind), .blk_user(blk_user),
        .blk_rsp_valid(blk_req), .blk_hit(blk_hit), .blk_raddr(BLK_RA), .blk_perm(blk_perm),
        .pt_req(pt_req), .pt_vsid(pt_vsid), .pt_ea(pt_ea), .pt_rsp_valid(pt_req & pt_gate),
        .pt_found(pt_found), .pt_rpn(RPN), .pt_pp(pt_pp),
        .done_valid(done_valid), .done_exc(done_exc), .done_code(done_code),
        .done_raddr(done_raddr), .done_perm(done_perm), .fault_addr(fault_addr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill_seg(input logic [31:0] ea, input logic [31:0] sr);
        for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = POISON;
        seg_regs[ea[31:28]*32 +: 32] = sr;
    endtask

    task automatic do_req(input int stall);
        pt_gate = (stall == 0);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_blk = 1'b0; got_pt = 1'b0; busy_bad = 1'b0; lat = 1;
        while (!done_valid && lat < 60) begin
            if (blk_req) got_blk = 1'b1;
            if (pt_req) got_pt = 1'b1;
            if (req_ready) busy_bad = 1'b1;
            if (lat == stall) pt_gate = 1'b1;
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic post_checks(input string tag);
        chk("R1", {tag, " ready back"}, {31'b0, req_ready}, 32'd1);
        chk("R1", {tag, " busy"}, {31'b0, busy_bad}, 32'd0);
        chk("R13", {tag, " fault_addr"}, fault_addr, exp_fa);
        @(negedge clk);
        chk("R1", {tag, " single pulse"}, {31'b0, done_valid}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset ready", {31'b0, req_ready}, 32'd1);
        chk("R1", "reset done", {31'b0, done_valid}, 32'd0);
        chk("R1", "reset fault_addr", fault_addr, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            req_kind = VECS[v].kind; req_fp = VECS[v].fp; req_user = VECS[v].user;
            xlate_fetch_en = VECS[v].ir; xlate_data_en = VECS[v].dr;
            blk_hit = VECS[v].bhit; blk_perm = VECS[v].bperm;
            pt_found = VECS[v].pfound; pt_pp = VECS[v].pp; req_ea = EA;
            fill_seg(EA, VECS[v].sr);
            do_req(0);
            if (VECS[v].xexc == 2'd2 || VECS[v].xexc == 2'd3) exp_fa = EA;
            chk(TAGS[v], "done seen", {31'b0, done_valid}, 32'd1);
            chk(TAGS[v], "exc", {30'b0, done_exc}, {30'b0, VECS[v].xexc});
            chk(TAGS[v], "code", done_code, VECS[v].xcode);
            chk(TAGS[v], "raddr", done_raddr, VECS[v].xraddr);
            chk(TAGS[v], "perm", {29'b0, done_perm}, {29'b0, VECS[v].xperm});
            chk(TAGS[v], "block asked", {31'b0, got_blk}, {31'b0, VECS[v].xblk});
            chk(TAGS[v], "search asked", {31'b0, got_pt}, {31'b0, VECS[v].xpt});
            if (VECS[v].xpt) chk("R5", "vsid", {8'b0, pt_vsid}, {8'b0, VECS[v].sr[23:0]});
            post_checks(TAGS[v]);
        end

        // R5 top segment: forced bus-unit segment in entry 15
        req_kind = 2'd0; req_fp = 1'b0; req_user = 1'b0;
        xlate_fetch_en = 1'b1; xlate_data_en = 1'b1; blk_hit = 1'b0;
        req_ea = 32'hF000_0123;
        fill_seg(req_ea, 32'h87F0_000C);
        do_req(0);
        chk("R5", "seg15 raddr", done_raddr, 32'hC000_0123);
        chk("R5", "seg15 perm", {29'b0, done_perm}, 32'd7);
        post_checks("R5");

        // R5 bottom segment, highest offset
        req_ea = 32'h0FFF_FFFF;
        fill_seg(req_ea, 32'h87F0_0009);
        do_req(0);
        chk("R5", "seg0 raddr", done_raddr, 32'h9FFF_FFFF);
        post_checks("R5");

        // R1 stalled searcher: outcome waits for the response
        req_ea = EA; pt_found = 1'b1; pt_pp = 2'd2;
        fill_seg(EA, 32'h0000_0456);
        do_req(6);
        chk("R1", "stall latency", {31'b0, (lat > 6)}, 32'd1);
        chk("R12", "stall raddr", done_raddr, PT_RA);
        post_checks("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule